// File: doc/BRIEF.md
# Parity-Framed Serial Transmitter

The block serialises one byte at a time onto an asynchronous line. A byte written on the parallel side waits in a one-entry holding register. When no frame is on the line, the byte moves into a shift register and goes out as eleven bit periods: a low start bit, the eight data bits least significant first, a parity bit, and a high stop bit. The block does not make its own baud timing. An enable pulse at sixteen times the bit rate, produced elsewhere, drives it, and a free-running divide-by-16 turns that enable into the bit tick.

End of data is not counted. When the register loads, two marker ones sit above the data byte, and each right shift brings a zero in at the top. The parity and stop slots are recognised when only those marker ones are left in the register, and the frame is over when the register is all zero. The parity sense is taken from a select input when the byte is loaded. A flag tells the writer when the holding register can take another byte.

Top module: `ser_frame_tx`

## Requirements
- R1: While `rst_n` is low, `tx` is 1 and `hold_empty` is 1. Both keep these values on the first edge after reset is released.
- R2: A bit tick happens on every 16th clock edge at which `os_en` is 1, counted from reset. `tx` changes only on a bit tick. When `os_en` stays 0, `tx` holds its value.
- R3: A frame on `tx` is: start bit 0, then data bits 0 to 7 in that order, then the parity bit, then stop bit 1. Each of these lasts one bit period (16 `os_en` pulses).
- R4: The parity bit is the XOR of the eight data bits, inverted when `odd_par` is 1. `odd_par` is sampled when the byte is loaded. With odd parity, byte 8'h0F is sent with a parity bit of 1.
- R5: A write (`wr_en`=1) while `hold_empty`=1 stores `wr_data`, and `hold_empty` reads 0 after that edge.
- R6: A write while `hold_empty`=0 is ignored. The byte already held is the one transmitted.
- R7: The held byte is loaded on a bit tick when no frame is in progress. On that same edge `tx` goes to 0 (start bit) and `hold_empty` goes to 1.
- R8: If a byte is waiting when a stop bit ends, the next start bit follows at once, so back-to-back frames are 176 `os_en` pulses apart.
- R9: When no frame is in progress, `tx` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_en | input | 1 | Enable at 16 times the bit rate |
| wr_data | input | 8 | Byte to send |
| wr_en | input | 1 | Write strobe for `wr_data` |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even |
| tx | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can take a byte |

## Verification
A corrupted marker pattern in the shift register shows up on `tx` within one bit period. Parity lands in the wrong slot, the stop bit comes early or late, or the start bit of the next frame moves. A divider phase error shifts every `tx` edge by a whole number of enable pulses, and the cycle-exact reference catches this on the first transition. A holding-register fault appears on `hold_empty` on the edge right after the write. If that flag is not wrong, it appears as a wrong byte in the next frame.

// File: rtl/ser_tx_pkg.sv
// Shared definitions for the serial frame transmitter.
// Assumes one start bit, one parity bit and one stop bit per frame.
package ser_tx_pkg;

    // Operating mode of the transmit control, decoded every cycle.
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_SHIFT = 2'd2
    } tx_mode_e;

    // Number of marker ones placed above the data byte at load time.
    localparam int unsigned MARK_BITS = 2;

endpackage

// File: rtl/ser_tx_rate_div.sv
// Divides the oversampling enable down to one bit tick per bit period.
// Assumes os_en is a single-cycle qualifier. The phase runs freely from reset.
module ser_tx_rate_div #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_en,
    output logic bit_tick
);
    localparam int unsigned CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] phase;

    // Count enable pulses and wrap after the last one of a bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (os_en) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign bit_tick = os_en && (phase == LAST);
endmodule

// File: rtl/ser_tx_hold.sv
// One-entry holding register between the parallel writer and the shifter.
// Assumes take is only asserted while full, so take and an accepted write never coincide.
module ser_tx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] held
);
    // Capture a byte when empty; free the entry when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            held <= wr_data;
        end
    end
endmodule

// File: rtl/ser_tx_shifter.sv
// Transmit shift register with marker fill, plus the parity latch.
// Loads {marker ones, byte} and shifts right with zero fill. The slots are read from the contents:
// only both marker ones left = parity slot, one left = stop slot, all zero = idle.
// Assumes advance is only asserted while a frame is in progress.
module ser_tx_shifter
    import ser_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-1:0] load_data,
    input  logic              odd_sel,
    output logic              data_bit,
    output logic              parity_slot,
    output logic              stop_slot,
    output logic              frame_idle,
    output logic              parity_bit
);
    localparam int unsigned SW = DATA_W + MARK_BITS;
    localparam logic [SW-1:0] PAR_MARK  = SW'(3);
    localparam logic [SW-1:0] STOP_MARK = SW'(1);

    logic [SW-1:0]     sr;
    logic [DATA_W-1:0] xor_chain;

    // XOR chain across the byte, built bit by bit.
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_par
            if (gi == 0) begin : g_first
                assign xor_chain[gi] = load_data[gi];
            end else begin : g_rest
                assign xor_chain[gi] = xor_chain[gi-1] ^ load_data[gi];
            end
        end
    endgenerate

    // Load byte with markers and latch parity; shift right on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr         <= '0;
            parity_bit <= 1'b0;
        end else if (load) begin
            sr         <= {{MARK_BITS{1'b1}}, load_data};
            parity_bit <= xor_chain[DATA_W-1] ^ odd_sel;
        end else if (advance) begin
            sr <= {1'b0, sr[SW-1:1]};
        end
    end

    assign data_bit    = sr[0];
    assign parity_slot = (sr == PAR_MARK);
    assign stop_slot   = (sr == STOP_MARK);
    assign frame_idle  = (sr == '0);
endmodule

// File: rtl/ser_frame_tx.sv
// Parity-framed asynchronous serial transmitter (top).
// Drives start, data LSB first, parity, stop on tx, one bit per bit tick.
// Assumes os_en arrives at 16x the bit rate from an external divider.
module ser_frame_tx
    import ser_tx_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              odd_par,
    output logic              tx,
    output logic              hold_empty
);
    logic              bit_tick;
    logic              hold_full;
    logic [DATA_W-1:0] held_byte;
    logic              data_bit;
    logic              parity_slot;
    logic              stop_slot;
    logic              frame_idle;
    logic              parity_bit;
    logic              load_go;
    logic              shift_go;
    tx_mode_e          mode;

    ser_tx_rate_div #(.OVERSAMPLE(OVERSAMPLE)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_en    (os_en),
        .bit_tick (bit_tick)
    );

    ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load_go),
        .full    (hold_full),
        .held    (held_byte)
    );

    ser_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_go),
        .advance     (shift_go),
        .load_data   (held_byte),
        .odd_sel     (odd_par),
        .data_bit    (data_bit),
        .parity_slot (parity_slot),
        .stop_slot   (stop_slot),
        .frame_idle  (frame_idle),
        .parity_bit  (parity_bit)
    );

    // Decode the operating mode from shifter contents and latch state.
    always_comb begin
        if (!frame_idle)     mode = MODE_SHIFT;
        else if (hold_full)  mode = MODE_LOAD;
        else                 mode = MODE_IDLE;
    end

    assign load_go  = bit_tick && (mode == MODE_LOAD);
    assign shift_go = bit_tick && (mode == MODE_SHIFT);

    // Register the line level: stop, then parity, then data, on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx <= 1'b1;
        end else if (bit_tick) begin
            unique case (mode)
                MODE_LOAD:  tx <= 1'b0;
                MODE_SHIFT: begin
                    if (stop_slot)        tx <= 1'b1;
                    else if (parity_slot) tx <= parity_bit;
                    else                  tx <= data_bit;
                end
                default:    tx <= 1'b1;
            endcase
        end
    end

    assign hold_empty = !hold_full;
endmodule

// File: rtl/ser_frame_tx_chk.sv
// Property checker for ser_frame_tx, attached by bind below.
module ser_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic os_en,
    input logic wr_en,
    input logic tx,
    input logic hold_empty,
    input logic bit_tick,
    input logic stop_slot,
    input logic frame_idle,
    input logic load_go
);
    // R1: reset leaves the line high and the latch empty
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (tx && hold_empty));

    // R2: no enable, no line change
    assert_tx_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !os_en |=> $stable(tx));

    // R3: the stop slot drives a high level
    assert_stop_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && stop_slot) |=> tx);

    // R5: a write into an empty latch fills it
    assert_write_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> !hold_empty);

    // R6: a write into a full latch does not free it
    assert_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold_empty && !load_go) |=> !hold_empty);

    // R7: the latch frees on the same edge the start bit appears
    assert_start_with_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> !tx);

    // R9: idle shifter with nothing to load keeps the line high
    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idle && !load_go && tx) |=> tx);
endmodule

bind ser_frame_tx ser_frame_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_en      (os_en),
    .wr_en      (wr_en),
    .tx         (tx),
    .hold_empty (hold_empty),
    .bit_tick   (bit_tick),
    .stop_slot  (stop_slot),
    .frame_idle (frame_idle),
    .load_go    (load_go)
);

// File: tb/sim_ser_frame_tx.sv
// Bench: behavioural reference compared every clock, plus directed frame captures.
module sim_ser_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_en = 1'b0;
    logic       odd_par = 1'b0;
    logic       tx;
    logic       hold_empty;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int os_mode = 0; // 0 every cycle, 1 every third cycle, 2 off

    // Reference model state
    int       m_cnt = 0;
    int       m_k = 0;
    bit       m_full = 0;
    bit [7:0] m_byte = 0;
    bit [7:0] m_sh = 0;
    bit       m_par = 0;
    bit       m_tx = 1;

    always #2 clk = ~clk;

    ser_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .os_en(os_en), .wr_data(wr_data),
        .wr_en(wr_en), .odd_par(odd_par), .tx(tx), .hold_empty(hold_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model: bit counter in frame slots, updated on each edge.
    always @(posedge clk) begin
        bit bt;
        bit wr_ok;
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_k = 0; m_full = 0; m_tx = 1;
        end else begin
            bt = os_en && (m_cnt == 15);
            if (os_en) m_cnt = (m_cnt + 1) % 16;
            wr_ok = wr_en && !m_full;
            if (bt) begin
                if (m_k == 0) begin
                    if (m_full) begin
                        m_tx = 0; m_sh = m_byte; m_par = (^m_byte) ^ odd_par;
                        m_k = 1; m_full = 0;
                    end else m_tx = 1;
                end else if (m_k <= 8) begin
                    m_tx = m_sh[m_k-1]; m_k++;
                end else if (m_k == 9) begin
                    m_tx = m_par; m_k = 10;
                end else begin
                    m_tx = 1; m_k = 0;
                end
            end
            if (wr_ok) begin m_full = 1; m_byte = wr_data; end
        end
    end

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(tx === m_tx, "R3 tx vs model", tx, m_tx);
            check(hold_empty === !m_full, "R5 hold_empty vs model", hold_empty, !m_full);
        end
    end

    // Oversampling enable pattern generator.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 3;
            case (os_mode)
                0: os_en = 1'b1;
                1: os_en = (ph == 0);
                default: os_en = 1'b0;
            endcase
        end
    end

    task automatic write_byte(input logic [7:0] b);
        bit was_empty;
        @(negedge clk);
        was_empty = hold_empty;
        wr_data = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (was_empty) check(hold_empty === 1'b0, "R5 fill on write", hold_empty, 0);
    endtask

    // Wait for a start bit and sample each slot in the middle of its bit period.
    task automatic capture(output logic [10:0] f, output bit flag_at_start);
        int n = 0;
        do @(negedge clk); while (tx !== 1'b0);
        flag_at_start = hold_empty;
        for (int i = 0; i < 11; i++) begin
            while (n < 8 + 16 * i) begin
                @(posedge clk);
                if (os_en) n++;
            end
            @(negedge clk);
            f[i] = tx;
        end
    endtask

    task automatic check_frame(input logic [10:0] f, input logic [7:0] b, input bit odd);
        logic expp;
        expp = (^b) ^ odd;
        check(f[0] === 1'b0, "R3 start bit", f[0], 0);
        check(f[8:1] === b, "R3 data LSB first", f[8:1], b);
        check(f[9] === expp, "R4 parity bit", f[9], expp);
        check(f[10] === 1'b1, "R3 stop bit", f[10], 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait (cycles >= 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] f;
        bit fl;
        logic hold_tx;
        repeat (5) @(negedge clk);
        check(tx === 1'b1, "R1 reset tx", tx, 1);
        check(hold_empty === 1'b1, "R1 reset hold_empty", hold_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx === 1'b1 && hold_empty === 1'b1, "R1 after release", {tx, hold_empty}, 3);

        // Odd parity on 8'h0F gives parity 1
        odd_par = 1'b1;
        write_byte(8'h0F);
        capture(f, fl);
        check(fl === 1'b1, "R7 flag frees with start bit", fl, 1);
        check_frame(f, 8'h0F, 1'b1);
        repeat (40) @(negedge clk);

        // Even parity patterns
        odd_par = 1'b0;
        write_byte(8'hA5);
        capture(f, fl);
        check_frame(f, 8'hA5, 1'b0);
        odd_par = 1'b1;
        write_byte(8'h01);
        capture(f, fl);
        check_frame(f, 8'h01, 1'b1);
        repeat (40) @(negedge clk);

        // R6: second write while full is dropped
        write_byte(8'h3C);
        check(hold_empty === 1'b0, "R6 latch full before second write", hold_empty, 0);
        write_byte(8'hC3);
        capture(f, fl);
        check(f[8:1] === 8'h3C, "R6 held byte kept", f[8:1], 8'h3C);
        repeat (40) @(negedge clk);
        check(tx === 1'b1, "R9 idle line high", tx, 1);
        check(hold_empty === 1'b1, "R6 dropped byte not queued", hold_empty, 1);

        // R8: back-to-back frames
        write_byte(8'h55);
        do @(negedge clk); while (tx !== 1'b0);
        fork
            write_byte(8'h96);
        join_none
        repeat (175) @(negedge clk);
        check(tx === 1'b1, "R8 stop before next frame", tx, 1);
        @(negedge clk);
        check(tx === 1'b0, "R8 next start immediately", tx, 0);
        repeat (200) @(negedge clk);

        // R2: sparse enable stretches the frame but not its content
        os_mode = 1;
        odd_par = 1'b1;
        write_byte(8'hE7);
        capture(f, fl);
        check_frame(f, 8'hE7, 1'b1);
        repeat (120) @(negedge clk);

        // R2: enable off mid-frame freezes the line
        os_mode = 0;
        write_byte(8'h12);
        do @(negedge clk); while (tx !== 1'b0);
        repeat (20) @(negedge clk);
        os_mode = 2;
        repeat (2) @(negedge clk);
        hold_tx = tx;
        repeat (40) @(negedge clk);
        check(tx === hold_tx, "R2 frozen without enable", tx, hold_tx);
        os_mode = 0;
        repeat (250) @(negedge clk);
        check(tx === 1'b1, "R9 idle after frame", tx, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule